// File: doc/BRIEF.md
# CPU Reset and Power-Up Sequencer

This block brings an 8-bit accumulator CPU core to a defined state after a cold power-up or a warm reset, and then fetches the start address. A cold start clears the general registers and the status flags. A warm reset keeps the live register values, which it takes from the core's register file on the `arch_*_i` inputs. In both cases the interrupt-disable flag is set.

The sequence reuses the seven-cycle interrupt-entry shape. It has two dummy reads and three stack cycles, which would push PC high, PC low and status. Two vector reads close it. The stack cycles are turned into reads, so memory is never written, but the stack pointer still steps down once per cycle. The result is a net decrement of three.

The state machine has eight states:

| State | Role |
|---|---|
| IDLE0, IDLE1 | Dummy reads at the captured PC |
| PUSH_PCH, PUSH_PCL, PUSH_P | Stack reads; S decrements after each one |
| VEC_LO, VEC_HI | Vector fetch |
| RUN | Sequence finished |

Transitions:
- Any active request forces IDLE0.
- With no request, each state advances to the next in the order above.
- RUN holds.

The power-on input resets asynchronously. The warm reset input is sampled on the clock.

Top module: `cpu_reset_seq`

## Requirements
- R1: While `por_i` is high or after its release, A, X, Y and the captured PC are 0. P is 0x04, which means bit 2 (I) is set and every other bit is clear. S starts the sequence at 0x00 and ends at 0xFD.
- R2: A clock edge with `rst_i` high and `por_i` low captures the following from the `arch_*_i` inputs:
  - A, X, Y, S and PC unchanged.
  - P equal to `arch_p_i` with bit 2 forced to 1.
  - At the end of the sequence, S equals the captured value minus 3, modulo 256.
- R3: The sequence spans exactly 7 cycles. Cycle 1 is the first cycle in which both requests are low. The read addresses are:
  - Cycles 1 and 2: the captured PC.
  - Cycles 3, 4 and 5: 0x0100 + S, using S before that cycle's decrement.
  - Cycle 6: 0xFFFC.
  - Cycle 7: 0xFFFD.
- R4: `rd_o` is high in all 7 sequence cycles.
- R5: `we_o` is low in every cycle, stack cycles included.
- R6: After the sequence, PC equals {byte read at 0xFFFD, byte read at 0xFFFC}.
- R7: `done_o` is high in cycle 7 only.
- R8: A request asserted in any cycle of the sequence restarts it from cycle 1, using freshly captured values.
- R9: When `por_i` and `rst_i` are high together, cold-start values are applied.
- R10: After the sequence, `rd_o`, `done_o` and `addr_o` stay at 0 and every register output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on request, asynchronous, active high |
| rst_i | input | 1 | Warm reset request, synchronous, active high |
| rdata_i | input | 8 | Read data from the memory bus |
| arch_a_i | input | 8 | Live accumulator from the core |
| arch_x_i | input | 8 | Live X index from the core |
| arch_y_i | input | 8 | Live Y index from the core |
| arch_s_i | input | 8 | Live stack pointer from the core |
| arch_p_i | input | 8 | Live status byte from the core |
| arch_pc_i | input | 16 | Live program counter from the core |
| addr_o | output | 16 | Bus address |
| rd_o | output | 1 | Read strobe |
| we_o | output | 1 | Write enable, always low |
| a_o | output | 8 | Accumulator value to load |
| x_o | output | 8 | X value to load |
| y_o | output | 8 | Y value to load |
| s_o | output | 8 | Stack pointer value to load |
| p_o | output | 8 | Status value to load |
| pc_o | output | 16 | Program counter value to load |
| done_o | output | 1 | High in the last sequence cycle |

## Verification
The bench uses the default build: an 8-bit data path, a 16-bit address, the vector at 0xFFFC and the stack page at 0x01. Because the stack pointer is only 8 bits wide, the bench can run a warm reset from every one of the 256 starting values. This covers the wrap through 0x00, 0x01 and 0x02, and every stack address on each stack cycle. It also injects a restart in each of the seven cycle positions, and it drives both requests at once while the warm inputs carry non-zero values.

// File: rtl/cpu_rst_pkg.sv
package cpu_rst_pkg;

    typedef enum logic [3:0] {
        ST_IDLE0,
        ST_IDLE1,
        ST_PUSH_PCH,
        ST_PUSH_PCL,
        ST_PUSH_P,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_RUN
    } rst_state_t;

endpackage

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import cpu_rst_pkg::*;
(
    input  logic       clk,
    input  logic       por_i,
    input  logic       rst_i,
    output rst_state_t state_o
);

    rst_state_t state_q;
    rst_state_t state_d;

    // Successor of each state when no request is active
    always_comb begin
        unique case (state_q)
            ST_IDLE0:    state_d = ST_IDLE1;
            ST_IDLE1:    state_d = ST_PUSH_PCH;
            ST_PUSH_PCH: state_d = ST_PUSH_PCL;
            ST_PUSH_PCL: state_d = ST_PUSH_P;
            ST_PUSH_P:   state_d = ST_VEC_LO;
            ST_VEC_LO:   state_d = ST_VEC_HI;
            ST_VEC_HI:   state_d = ST_RUN;
            ST_RUN:      state_d = ST_RUN;
            default:     state_d = ST_RUN;
        endcase
    end

    // Power-on is asynchronous and wins; warm reset restarts on the clock
    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            state_q <= ST_IDLE0;
        end else if (rst_i) begin
            state_q <= ST_IDLE0;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/rst_arch_regs.sv
module rst_arch_regs #(
    parameter int          DW      = 8,
    parameter int          AW      = 2 * DW,
    parameter int          P_IFLAG = 2
) (
    input  logic          clk,
    input  logic          por_i,
    input  logic          rst_i,
    input  logic          sp_dec_i,
    input  logic          vlo_ld_i,
    input  logic          pc_ld_i,
    input  logic [DW-1:0] rdata_i,
    input  logic [DW-1:0] arch_a_i,
    input  logic [DW-1:0] arch_x_i,
    input  logic [DW-1:0] arch_y_i,
    input  logic [DW-1:0] arch_s_i,
    input  logic [DW-1:0] arch_p_i,
    input  logic [AW-1:0] arch_pc_i,
    output logic [DW-1:0] a_o,
    output logic [DW-1:0] x_o,
    output logic [DW-1:0] y_o,
    output logic [DW-1:0] s_o,
    output logic [DW-1:0] p_o,
    output logic [AW-1:0] pc_o
);

    localparam logic [DW-1:0] IMASK = DW'(1) << P_IFLAG;

    logic [DW-1:0] vlo_q;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            a_o   <= '0;
            x_o   <= '0;
            y_o   <= '0;
            s_o   <= '0;
            p_o   <= IMASK;
            pc_o  <= '0;
            vlo_q <= '0;
        end else if (rst_i) begin
            a_o  <= arch_a_i;
            x_o  <= arch_x_i;
            y_o  <= arch_y_i;
            s_o  <= arch_s_i;
            p_o  <= arch_p_i | IMASK;
            pc_o <= arch_pc_i;
        end else begin
            if (sp_dec_i) begin
                s_o <= s_o - DW'(1);
            end
            if (vlo_ld_i) begin
                vlo_q <= rdata_i;
            end
            if (pc_ld_i) begin
                pc_o <= {rdata_i, vlo_q};
            end
        end
    end

endmodule

// File: rtl/cpu_reset_seq.sv
module cpu_reset_seq
    import cpu_rst_pkg::*;
#(
    parameter int          DW         = 8,
    parameter int          AW         = 16,
    parameter logic [15:0] VEC_ADDR   = 16'hFFFC,
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter int          P_IFLAG    = 2
) (
    input  logic          clk,
    input  logic          por_i,
    input  logic          rst_i,
    input  logic [DW-1:0] rdata_i,
    input  logic [DW-1:0] arch_a_i,
    input  logic [DW-1:0] arch_x_i,
    input  logic [DW-1:0] arch_y_i,
    input  logic [DW-1:0] arch_s_i,
    input  logic [DW-1:0] arch_p_i,
    input  logic [AW-1:0] arch_pc_i,
    output logic [AW-1:0] addr_o,
    output logic          rd_o,
    output logic          we_o,
    output logic [DW-1:0] a_o,
    output logic [DW-1:0] x_o,
    output logic [DW-1:0] y_o,
    output logic [DW-1:0] s_o,
    output logic [DW-1:0] p_o,
    output logic [AW-1:0] pc_o,
    output logic          done_o
);

    localparam logic [AW-1:0] VEC_LO_A = AW'(VEC_ADDR);
    localparam logic [AW-1:0] VEC_HI_A = AW'(VEC_ADDR) + AW'(1);
    localparam int            PAGE_W   = AW - DW;

    rst_state_t state;
    logic       sp_dec;
    logic       vlo_ld;
    logic       pc_ld;

    rst_seq_fsm u_fsm (
        .clk     (clk),
        .por_i   (por_i),
        .rst_i   (rst_i),
        .state_o (state)
    );

    rst_arch_regs #(
        .DW      (DW),
        .AW      (AW),
        .P_IFLAG (P_IFLAG)
    ) u_regs (
        .clk       (clk),
        .por_i     (por_i),
        .rst_i     (rst_i),
        .sp_dec_i  (sp_dec),
        .vlo_ld_i  (vlo_ld),
        .pc_ld_i   (pc_ld),
        .rdata_i   (rdata_i),
        .arch_a_i  (arch_a_i),
        .arch_x_i  (arch_x_i),
        .arch_y_i  (arch_y_i),
        .arch_s_i  (arch_s_i),
        .arch_p_i  (arch_p_i),
        .arch_pc_i (arch_pc_i),
        .a_o       (a_o),
        .x_o       (x_o),
        .y_o       (y_o),
        .s_o       (s_o),
        .p_o       (p_o),
        .pc_o      (pc_o)
    );

    // Output decode. The push cycles of the shared entry path become reads,
    // so the write strobe stays low in every state.
    always_comb begin
        addr_o = '0;
        rd_o   = 1'b0;
        we_o   = 1'b0;
        done_o = 1'b0;
        sp_dec = 1'b0;
        vlo_ld = 1'b0;
        pc_ld  = 1'b0;
        unique case (state)
            ST_IDLE0, ST_IDLE1: begin
                addr_o = pc_o;
                rd_o   = 1'b1;
            end
            ST_PUSH_PCH, ST_PUSH_PCL, ST_PUSH_P: begin
                addr_o = {STACK_PAGE[PAGE_W-1:0], s_o};
                rd_o   = 1'b1;
                sp_dec = 1'b1;
            end
            ST_VEC_LO: begin
                addr_o = VEC_LO_A;
                rd_o   = 1'b1;
                vlo_ld = 1'b1;
            end
            ST_VEC_HI: begin
                addr_o = VEC_HI_A;
                rd_o   = 1'b1;
                done_o = 1'b1;
                pc_ld  = 1'b1;
            end
            ST_RUN: begin
                addr_o = '0;
            end
            default: begin
                addr_o = '0;
            end
        endcase
    end

    // R2, R3: each stack cycle lowers S by one
    a_r3_sp_step: assert property (@(posedge clk) disable iff (por_i || rst_i)
        (state == ST_PUSH_PCH || state == ST_PUSH_PCL || state == ST_PUSH_P)
        |=> s_o == $past(s_o) - DW'(1));

    // R3: the vector high read directly follows the vector low read
    a_r3_vec_order: assert property (@(posedge clk) disable iff (por_i || rst_i)
        (addr_o == VEC_LO_A && rd_o) |=> (addr_o == VEC_HI_A && done_o));

    // R6: PC high byte comes from the vector high read
    a_r6_pc_hi: assert property (@(posedge clk) disable iff (por_i || rst_i)
        done_o |=> pc_o[AW-1:DW] == $past(rdata_i));

    // R7: done lasts a single cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (por_i || rst_i)
        done_o |=> !done_o);

    // R1, R2: the interrupt-disable flag is set by the time done is raised
    a_r2_iflag: assert property (@(posedge clk) disable iff (por_i || rst_i)
        done_o |-> p_o[P_IFLAG]);

    // R10: registers hold once the sequence has finished
    a_r10_hold: assert property (@(posedge clk) disable iff (por_i || rst_i)
        (state == ST_RUN) |=> ($stable(s_o) && $stable(pc_o) && $stable(p_o)));

endmodule

// File: tb/cpu_reset_seq_bench.sv
module cpu_reset_seq_bench;

    logic        clk = 1'b0;
    logic        por = 1'b0;
    logic        rst = 1'b0;
    logic [7:0]  rdata;
    logic [7:0]  aa = '0, ax = '0, ay = '0, as_ = '0, ap = '0;
    logic [15:0] apc = '0;
    logic [15:0] addr, pc;
    logic        rd, we, done;
    logic [7:0]  a, x, y, s, p;
    logic [7:0]  vlo = 8'h00, vhi = 8'h80;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // Bus model: vector bytes at 0xFFFC/0xFFFD, filler elsewhere
    assign rdata = (addr == 16'hFFFC) ? vlo :
                   (addr == 16'hFFFD) ? vhi : (addr[7:0] ^ 8'hA5);

    cpu_reset_seq u_cpu_reset_seq (
        .clk (clk), .por_i (por), .rst_i (rst), .rdata_i (rdata),
        .arch_a_i (aa), .arch_x_i (ax), .arch_y_i (ay), .arch_s_i (as_),
        .arch_p_i (ap), .arch_pc_i (apc),
        .addr_o (addr), .rd_o (rd), .we_o (we),
        .a_o (a), .x_o (x), .y_o (y), .s_o (s), .p_o (p), .pc_o (pc),
        .done_o (done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge in cycle 1 of a sequence
    task automatic run_seq(input logic [15:0] pc0, input logic [7:0] s0,
                           input logic [7:0] ea, input logic [7:0] ex,
                           input logic [7:0] ey, input logic [7:0] ep);
        logic [15:0] ea_exp;
        for (int i = 0; i < 7; i++) begin
            if (i < 2)       ea_exp = pc0;
            else if (i < 5)  ea_exp = {8'h01, 8'(s0 - 8'(i - 2))};
            else if (i == 5) ea_exp = 16'hFFFC;
            else             ea_exp = 16'hFFFD;
            chk(addr == ea_exp, "R3 address", 32'(addr), 32'(ea_exp));
            chk(rd == 1'b1, "R4 read strobe", 32'(rd), 1);
            chk(we == 1'b0, "R5 write enable", 32'(we), 0);
            chk(done == (i == 6), "R7 done", 32'(done), 32'(i == 6));
            @(posedge clk);
            @(negedge clk);
        end
        chk(s == 8'(s0 - 8'd3), "R2 stack pointer", 32'(s), 32'(s0 - 8'd3));
        chk(pc == {vhi, vlo}, "R6 pc", 32'(pc), 32'({vhi, vlo}));
        chk({a, x, y} == {ea, ex, ey}, "R2 AXY", 32'({a, x, y}), 32'({ea, ex, ey}));
        chk(p == ep, "R2 status", 32'(p), 32'(ep));
        chk(!rd && !done && addr == 16'h0 && !we, "R10 idle",
            32'({rd, done, we, addr}), 0);
        @(posedge clk);
        @(negedge clk);
        chk(pc == {vhi, vlo} && s == 8'(s0 - 8'd3), "R10 hold", 32'(pc), 32'({vhi, vlo}));
    endtask

    task automatic set_arch(input logic [7:0] k);
        aa = k ^ 8'h3C; ax = k + 8'd1; ay = ~k; as_ = k; ap = k;
        apc = {k, ~k}; vlo = k + 8'd7; vhi = k ^ 8'h81;
    endtask

    task automatic warm_pulse();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: cold start while the warm inputs carry junk
        set_arch(8'h5B);
        @(negedge clk);
        por = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(we == 1'b0 && rd == 1'b1, "R1 reset state", 32'({we, rd}), 1);
        chk(s == 8'h00 && p == 8'h04, "R1 cold S/P", 32'({s, p}), 32'h0004);
        por = 1'b0;
        run_seq(16'h0000, 8'h00, 8'h00, 8'h00, 8'h00, 8'h04);
        chk(s == 8'hFD, "R1 cold final S", 32'(s), 32'hFD);

        // R2: warm reset from every stack pointer value
        for (int k = 0; k < 256; k++) begin
            set_arch(8'(k));
            warm_pulse();
            run_seq({8'(k), ~8'(k)}, 8'(k), 8'(k) ^ 8'h3C, 8'(k) + 8'd1, ~8'(k),
                    8'(k) | 8'h04);
        end

        // R8: restart injected in every sequence cycle
        for (int c = 0; c < 7; c++) begin
            set_arch(8'h20);
            warm_pulse();
            repeat (c) begin
                @(posedge clk);
                @(negedge clk);
            end
            set_arch(8'h91);
            warm_pulse();
            run_seq(16'h916E, 8'h91, 8'h91 ^ 8'h3C, 8'h92, 8'h6E, 8'h95);
        end

        // R9: both requests together give a cold start
        set_arch(8'hC3);
        por = 1'b1;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        por = 1'b0;
        rst = 1'b0;
        run_seq(16'h0000, 8'h00, 8'h00, 8'h00, 8'h00, 8'h04);

        // R1: cold start arriving in the middle of a warm sequence
        set_arch(8'h44);
        warm_pulse();
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        por = 1'b1;
        @(negedge clk);
        por = 1'b0;
        run_seq(16'h0000, 8'h00, 8'h00, 8'h00, 8'h00, 8'h04);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule